// File: doc/BRIEF.md
# Crystal-Clocked Timer Bridge

This block is an 8-bit timer whose counting logic runs either from the bus clock or from a separate crystal clock input. A clock-select bit in the status register chooses between the two. When the crystal clock is selected, bus writes to the count, compare and control registers are not applied directly. Each write is held in a per-register staging register and handed to the timer domain with a toggle handshake. A busy bit for each register stays set until the timer side confirms that it loaded the value.

Each transfer channel is a two-state machine. **CH_IDLE** moves to **CH_WAIT** (transition *launch*) when a write is accepted in crystal mode. **CH_WAIT** returns to **CH_IDLE** (transition *acknowledge*) once the returned acknowledge toggle matches the request toggle. In bus-clock mode an accepted write updates the staged copy and the live register on the same edge, and the channel stays in CH_IDLE. A write that arrives while its channel is in CH_WAIT is dropped (transition *collide*, the channel stays in CH_WAIT) and sets a sticky collision flag.

Two timer events cross back to the bus domain as toggles and become sticky flags that software clears by writing 1: counter overflow and compare match. The running count crosses as a Gray code. Reads of the count register return this synchronized count. Reads of the compare and control registers return the staged copy.

Top module: `xtal_timer_bridge`

## Requirements
- R1: Register addresses are 0 status, 1 count, 2 compare, 3 control, 4 flags and 5 interrupt enable. Status bit 3 is clock select, bit 2 is count busy, bit 1 is compare busy and bit 0 is control busy. Status bits 7..4 read as zero, and a write to status changes only bit 3. Every register resets to zero.
- R2: With clock select 0, a write updates the live register and its staged copy on the same edge, and the busy bits stay 0.
- R3: With clock select 1, a write to count, compare or control stores the data in that register's staging register and sets that register's busy bit on the next edge.
- R4: A busy bit clears only after the timer domain has loaded the staged value. The staged value stays unchanged while the bit is set. After the bit clears, the loaded value is visible in the timer.
- R5: A count read returns the running count through a Gray-code synchronizer, so the read lags the timer by a few bus cycles. Compare and control reads return the staged copy.
- R6: A write to a register whose busy bit is set is discarded and sets flag bit 2 (collision).
- R7: The counter advances by one on each timer clock edge while control bit 0 is 1. It holds while control bit 0 is 0. A loaded value takes precedence over the increment.
- R8: Flag bit 0 is set when the count wraps from 0xFF to 0x00. Flag bit 1 is set when an increment makes the count equal to the compare value. Flags are sticky, a 1 written to a flag bit clears it, and a new event in the same cycle wins over the clear.
- R9: The `irq` output is high when (flag bit 0 and enable bit 0) or (flag bit 1 and enable bit 1).
- R10: With clock select 1 the timer runs only on `xclk`. If `xclk` is stopped, staged transfers stay pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the timer clock when clock select is 0 |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| xclk | input | 1 | Crystal clock for the timer when clock select is 1 |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Enabled event flag pending |

## Verification
The bench writes all three registers back to back in crystal mode. Status must read 0x0F while the transfers are pending. A second compare write during that window must leave the staged value untouched and raise the collision flag. A design that let the write through would corrupt the transfer in flight. The bench also stops `xclk` and confirms that the busy bit stays set. A design that cleared busy without the acknowledge would fail that check. In both clock modes the bench runs the counter across 0xFF and across the compare value to catch lost or doubled event flags. It also reads the count twice after stopping to catch torn or drifting count reads.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
    localparam int ADDR_W   = 3;
    localparam int NUM_CH   = 3;
    localparam int NUM_EV   = 2;
    localparam int CH_CTL   = 0;
    localparam int CH_CMP   = 1;
    localparam int CH_CNT   = 2;
    localparam int ST_SEL   = 3;
    localparam int FL_OVF   = 0;
    localparam int FL_MAT   = 1;
    localparam int FL_COL   = 2;
    localparam int FL_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 3'd0,
        REG_CNT  = 3'd1,
        REG_CMP  = 3'd2,
        REG_CTL  = 3'd3,
        REG_FLG  = 3'd4,
        REG_IEN  = 3'd5
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_WAIT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/xtb_chan.sv
module xtb_chan
    import xtb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         bclk,
    input  logic         tclk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic         async_mode,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stage,
    output logic         busy,
    output logic         collide,
    output logic         load_t
);
    ch_state_e state, state_nx;
    logic      req_tgl;
    logic      ack_s1, ack_s2;
    logic      req_s1, req_s2, ack_tgl;
    logic      accept;
    logic      ack_done;

    assign accept   = wr_req && (state == CH_IDLE);
    assign ack_done = (ack_s2 == req_tgl);

    // state register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // next state: launch, acknowledge, collide (stay)
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (accept && async_mode) state_nx = CH_WAIT;
            CH_WAIT: if (ack_done)             state_nx = CH_IDLE;
        endcase
    end

    // bus-side outputs and staging
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            stage   <= '0;
            req_tgl <= 1'b0;
            ack_s1  <= 1'b0;
            ack_s2  <= 1'b0;
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
            if (accept) begin
                stage <= wdata;
                if (async_mode) req_tgl <= ~req_tgl;
            end
        end
    end

    assign busy    = (state == CH_WAIT);
    assign collide = wr_req && (state == CH_WAIT);

    // timer-side receive of the request toggle
    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            req_s1  <= 1'b0;
            req_s2  <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            req_s1  <= req_tgl;
            req_s2  <= req_s1;
            ack_tgl <= req_s2;
        end
    end

    assign load_t = req_s2 ^ ack_tgl;
endmodule

// File: rtl/xtb_core.sv
module xtb_core
    import xtb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              tclk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dir_we,
    input  logic [W-1:0]      dir_data,
    input  logic [NUM_CH-1:0] load,
    input  logic [W-1:0]      stg_cnt,
    input  logic [W-1:0]      stg_cmp,
    input  logic              stg_run,
    output logic [W-1:0]      cnt_gray,
    output logic [NUM_EV-1:0] ev_tgl
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q, cnt_nx, cnt_inc;
    logic [W-1:0] cmp_q;
    logic         run_q;
    logic         step;

    assign cnt_inc = cnt_q + 1'b1;
    assign step    = run_q && !dir_we[CH_CNT] && !load[CH_CNT];

    always_comb begin
        if (dir_we[CH_CNT])    cnt_nx = dir_data;
        else if (load[CH_CNT]) cnt_nx = stg_cnt;
        else if (run_q)        cnt_nx = cnt_inc;
        else                   cnt_nx = cnt_q;
    end

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cmp_q    <= '0;
            run_q    <= 1'b0;
            cnt_gray <= '0;
            ev_tgl   <= '0;
        end else begin
            cnt_q    <= cnt_nx;
            cnt_gray <= cnt_nx ^ (cnt_nx >> 1);
            if (dir_we[CH_CMP])      cmp_q <= dir_data;
            else if (load[CH_CMP])   cmp_q <= stg_cmp;
            if (dir_we[CH_CTL])      run_q <= dir_data[0];
            else if (load[CH_CTL])   run_q <= stg_run;
            if (step && (cnt_q == CNT_MAX)) ev_tgl[FL_OVF] <= ~ev_tgl[FL_OVF];
            if (step && (cnt_inc == cmp_q)) ev_tgl[FL_MAT] <= ~ev_tgl[FL_MAT];
        end
    end
endmodule

// File: rtl/xtb_evt_sync.sv
module xtb_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tgl_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pulse = s2 ^ s3;
endmodule

// File: rtl/xtb_gray_sync.sv
module xtb_gray_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] g1, g2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g1 <= '0;
            g2 <= '0;
        end else begin
            g1 <= gray_in;
            g2 <= g1;
        end
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ g2[i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/xtal_timer_bridge.sv
module xtal_timer_bridge
    import xtb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xclk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq
);
    logic                clk_sel_q;
    logic                tclk;
    logic [NUM_CH-1:0]   wr_ch;
    logic [NUM_CH-1:0]   busy_vec;
    logic [NUM_CH-1:0]   col_vec;
    logic [NUM_CH-1:0]   load_vec;
    logic [NUM_CH-1:0]   dir_we;
    logic [W-1:0]        stage_ch [NUM_CH];
    logic [W-1:0]        cmp_stage;
    logic [W-1:0]        cnt_gray;
    logic [W-1:0]        cnt_bus;
    logic [NUM_EV-1:0]   ev_tgl;
    logic [NUM_EV-1:0]   ev_pulse;
    logic [FL_W-1:0]     flag_q;
    logic [FL_W-1:0]     flag_set;
    logic [FL_W-1:0]     flag_clr;
    logic [NUM_EV-1:0]   ien_q;

    assign tclk = clk_sel_q ? xclk : clk;

    assign wr_ch[CH_CNT] = wr_en && (addr == REG_CNT);
    assign wr_ch[CH_CMP] = wr_en && (addr == REG_CMP);
    assign wr_ch[CH_CTL] = wr_en && (addr == REG_CTL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign dir_we[c] = wr_ch[c] && !clk_sel_q && !busy_vec[c];
        xtb_chan #(.W(W)) u_chan (
            .bclk       (clk),
            .tclk       (tclk),
            .rst_n      (rst_n),
            .wr_req     (wr_ch[c]),
            .async_mode (clk_sel_q),
            .wdata      (wdata),
            .stage      (stage_ch[c]),
            .busy       (busy_vec[c]),
            .collide    (col_vec[c]),
            .load_t     (load_vec[c])
        );
    end

    assign cmp_stage = stage_ch[CH_CMP];

    xtb_core #(.W(W)) u_core (
        .tclk     (tclk),
        .rst_n    (rst_n),
        .dir_we   (dir_we),
        .dir_data (wdata),
        .load     (load_vec),
        .stg_cnt  (stage_ch[CH_CNT]),
        .stg_cmp  (stage_ch[CH_CMP]),
        .stg_run  (stage_ch[CH_CTL][0]),
        .cnt_gray (cnt_gray),
        .ev_tgl   (ev_tgl)
    );

    xtb_gray_sync #(.W(W)) u_gsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (cnt_gray),
        .bin_out (cnt_bus)
    );

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        xtb_evt_sync u_evs (
            .clk    (clk),
            .rst_n  (rst_n),
            .tgl_in (ev_tgl[e]),
            .pulse  (ev_pulse[e])
        );
    end

    assign flag_set = {|col_vec, ev_pulse};
    assign flag_clr = (wr_en && (addr == REG_FLG)) ? wdata[FL_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sel_q <= 1'b0;
            flag_q    <= '0;
            ien_q     <= '0;
        end else begin
            if (wr_en && (addr == REG_STAT)) clk_sel_q <= wdata[ST_SEL];
            if (wr_en && (addr == REG_IEN))  ien_q     <= wdata[NUM_EV-1:0];
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_STAT: rdata = {{(W-4){1'b0}}, clk_sel_q, busy_vec};
            REG_CNT:  rdata = cnt_bus;
            REG_CMP:  rdata = stage_ch[CH_CMP];
            REG_CTL:  rdata = stage_ch[CH_CTL];
            REG_FLG:  rdata = {{(W-FL_W){1'b0}}, flag_q};
            REG_IEN:  rdata = {{(W-NUM_EV){1'b0}}, ien_q};
            default:  rdata = '0;
        endcase
    end

    assign irq = |(flag_q[NUM_EV-1:0] & ien_q);
endmodule

// File: rtl/xtb_checker.sv
module xtb_checker
    import xtb_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic              clk_sel,
    input logic [NUM_CH-1:0] busy,
    input logic [W-1:0]      cmp_stage,
    input logic              ovf_flag,
    input logic              col_flag
);
    AST_ASYNC_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clk_sel && addr == REG_CNT && !busy[CH_CNT]) |=> busy[CH_CNT]); // R3

    AST_SYNC_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_sel && busy == '0) |=> (busy == '0)); // R2

    AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy[CH_CMP] |=> $stable(cmp_stage)); // R4

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CMP && busy[CH_CMP]) |=> col_flag); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && addr == REG_FLG && wdata[FL_OVF])) |=> ovf_flag); // R8
endmodule

bind xtal_timer_bridge xtb_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .clk_sel   (clk_sel_q),
    .busy      (busy_vec),
    .cmp_stage (cmp_stage),
    .ovf_flag  (flag_q[0]),
    .col_flag  (flag_q[2])
);

// File: tb/xtal_timer_bridge_bench.sv
`timescale 1ns/1ps
module xtal_timer_bridge_bench;
    logic       clk = 1'b0;
    logic       xclk = 1'b0;
    logic       xclk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    int         errors = 0;
    int         checks = 0;
    logic [7:0] v, v2;

    xtal_timer_bridge u_xtal_timer_bridge (
        .clk(clk), .rst_n(rst_n), .xclk(xclk), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;
    always begin
        #61;
        if (xclk_run) xclk = ~xclk;
    end

    // {write, addr, data, expected readback}; bus-clock mode (R2, R5)
    localparam int NV = 7;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 3'd2, 8'h37, 8'h37},
        {1'b1, 3'd3, 8'h80, 8'h80},
        {1'b1, 3'd1, 8'h5A, 8'h5A},
        {1'b0, 3'd0, 8'h00, 8'h00},
        {1'b1, 3'd5, 8'h02, 8'h02},
        {1'b1, 3'd5, 8'h00, 8'h00},
        {1'b1, 3'd4, 8'h07, 8'h00}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] s;
        s = 8'hFF;
        for (int k = 0; k < 400; k++) begin
            rd(3'd0, s);
            if (s[2:0] == 3'b000) break;
        end
        chk(s & 8'h07, 8'h00, tag);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(3'd0, v); chk(v, 8'h00, "R1 status reset");
        rd(3'd1, v); chk(v, 8'h00, "R1 count reset");
        rd(3'd4, v); chk(v, 8'h00, "R1 flags reset");
        chk({7'd0, irq}, 8'h00, "R9 irq reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            idle(6);
            rd(VEC[i][18:16], v);
            chk(v, VEC[i][7:0], $sformatf("R2 table entry %0d", i));
        end

        // R7 R8 R9 bus-clock run across 0xFF and compare 0x01
        wr(3'd1, 8'hFE);
        wr(3'd2, 8'h01);
        wr(3'd5, 8'h01);
        wr(3'd3, 8'h01);
        idle(10);
        wr(3'd3, 8'h00);
        idle(8);
        rd(3'd4, v); chk(v, 8'h03, "R8 sync overflow and match flags");
        chk({7'd0, irq}, 8'h01, "R9 irq with overflow enabled");
        rd(3'd1, v); idle(5); rd(3'd1, v2);
        chk(v2, v, "R7 count holds when stopped");
        wr(3'd4, 8'h03);
        rd(3'd4, v); chk(v, 8'h00, "R8 write-one clear");
        chk({7'd0, irq}, 8'h00, "R9 irq drops after clear");

        // safe switch to crystal clock
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h08);
        rd(3'd0, v); chk(v, 8'h08, "R1 clock select set");
        wr(3'd1, 8'hF0);
        wr(3'd2, 8'hF8);
        wr(3'd3, 8'h00);
        rd(3'd0, v); chk(v, 8'h0F, "R3 all busy after staged writes");
        rd(3'd2, v); chk(v, 8'hF8, "R5 compare read returns staged");
        wr(3'd2, 8'h11);
        rd(3'd2, v); chk(v, 8'hF8, "R6 write while busy dropped");
        rd(3'd4, v); chk(v, 8'h04, "R6 collision flag");
        wait_idle("R4 busy clears after transfer");
        idle(10);
        rd(3'd1, v); chk(v, 8'hF0, "R4 count loaded in timer");
        wr(3'd4, 8'h07);
        rd(3'd4, v); chk(v, 8'h00, "R6 collision cleared");

        // R1 status high bits
        wr(3'd0, 8'hF8);
        rd(3'd0, v); chk(v, 8'h08, "R1 status high bits zero");

        // R10 stalled crystal clock
        xclk_run = 1'b0;
        wr(3'd1, 8'h33);
        idle(60);
        rd(3'd0, v); chk(v, 8'h0C, "R10 transfer pending without xclk");
        xclk_run = 1'b1;
        wait_idle("R10 transfer completes on xclk");
        idle(10);
        rd(3'd1, v); chk(v, 8'h33, "R10 count after resume");

        // R7 R8 crystal-clock run
        wr(3'd1, 8'hF0);
        wait_idle("R4 count reload");
        wr(3'd4, 8'h07);
        wr(3'd3, 8'h01);
        idle(200);
        wr(3'd3, 8'h00);
        wait_idle("R4 control reload");
        idle(20);
        rd(3'd4, v); chk(v, 8'h03, "R8 async overflow and match");
        rd(3'd1, v); idle(8); rd(3'd1, v2);
        chk(v2, v, "R5 stable count read");
        chk((v != 8'hF0) ? 8'h01 : 8'h00, 8'h01, "R7 counter advanced on xclk");

        // safe switch back to bus clock
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h07);
        rd(3'd0, v); chk(v, 8'h00, "R2 back in bus-clock mode");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule